// File: doc/BRIEF.md
# Power-Gate Release Sequencer

This block is a small hardware sequencer that lifts a boot-time power gate from a graphics engine without software help. After a one-cycle start pulse it walks a fixed, ordered list of sixteen steps. Each step is a register field change, a plain register read or a long wait. It drives a simple memory-mapped bus as the master. Every field change is carried out as a read followed by a write to the same address. The write returns the value just read with only the one target bit replaced, so reserved bits are never disturbed.

The order of the steps is what releases the gate safely. The engine is first held disabled and its block-level gating controllers are switched on, followed by a long wait. A clamp-enable override is then pulsed with the clamp value set high. Next the boot power-gate override is forced to "off" and enabled, again followed by a long wait. The clamp is then pulsed a second time with the value low. Finally the gating controllers are switched off and the engine is enabled again, with a read closing the sequence.

Both waits last `DELAY_MS × CYCLES_PER_MS` clock cycles. A bench can shrink the wait by lowering `CYCLES_PER_MS`. The register addresses and the bit positions of all six fields are parameters.

Top module: `pgr_release_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all low and no bus transfer takes place until a start pulse arrives.
- R2: A `start` sampled high while the block is idle begins the sequence. `busy` is high from the cycle after that start until the final read completes. `done` is then high for exactly one cycle, and `busy` is already low in that cycle.
- R3: A `start` that arrives while `busy` is high has no effect: the run in progress continues unchanged and produces exactly one `done`.
- R4: A transfer completes on a clock edge where both `bus_req` and `bus_ready` are high (`bus_we` 1 = write, 0 = read; `bus_rdata` is taken on a read handshake). While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R5: Each field change is a read of the register followed directly by a write to the same address. The written word equals the word just read, with only the target bit set to the step's value.
- R6: The steps run in this order:
  - engine-enable register: clear the engine bit (default bit 12), then do a plain read, then set the gating-controller bit (default bit 27);
  - wait;
  - clamp register: set the clamp-value bit (default bit 1) to 1, then set the clamp-mask bit (default bit 0) to 1, then clear the clamp-mask bit;
  - thermal control register: clear the override-value bit (default bit 31), then set the override-enable bit (default bit 30);
  - wait;
  - clamp register: set the clamp-value bit to 0, then set the clamp-mask bit to 1, then clear the clamp-mask bit;
  - engine-enable register: clear bit 27, then set bit 12, then do a closing plain read.

  This makes 26 bus transfers in all.
- R7: At each wait, `bus_req` stays low for exactly `DELAY_MS*CYCLES_PER_MS + 2` cycles between the last transfer before the wait and the first transfer after it.
- R8: Between two consecutive non-wait steps, `bus_req` is low for exactly one cycle. Between the read and the write of one field change it does not drop at all.
- R9: Default addresses are 0x200 for the engine-enable register, 0x10A78C for the clamp register and 0x20004 for the thermal control register.
- R10: The wait timer never runs while a bus access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the closing read |
| bus_req | output | 1 | Transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid on a read handshake |
| bus_ready | input | 1 | Target accepts or completes the transfer |

## Verification
The assertions assume a target that eventually raises `bus_ready` while `bus_req` is high, and that keeps `bus_rdata` steady for the handshake cycle of a read. The bench's register model answers every request after a fixed latency of zero to three cycles, with read data taken straight from its own storage. That keeps the handshake and the hold assertions within those assumptions. The stimulus also injects start pulses both during a bus access and during a long wait, to show that a restart attempt never disturbs a run.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

  localparam int STEP_COUNT = 16;
  localparam int IDX_W      = $clog2(STEP_COUNT);
  localparam int POS_W      = 6;

  typedef enum logic [1:0] {
    OP_RMW  = 2'd0,
    OP_READ = 2'd1,
    OP_WAIT = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    RG_ENG   = 2'd0,
    RG_CLAMP = 2'd1,
    RG_THERM = 2'd2
  } reg_e;

  typedef struct packed {
    op_e              op;
    reg_e             rsel;
    logic [POS_W-1:0] pos;
    logic             val;
  } step_t;

  // Replace one bit of a word, leave all others untouched.
  function automatic logic [63:0] put_bit(logic [63:0] w, logic [POS_W-1:0] pos, logic v);
    logic [63:0] r;
    r      = w;
    r[pos] = v;
    return r;
  endfunction

  function automatic logic is_last(logic [IDX_W-1:0] idx);
    return idx == IDX_W'(STEP_COUNT - 1);
  endfunction

  function automatic int wait_cycles(int per_ms, int ms);
    return per_ms * ms;
  endfunction

endpackage

// File: rtl/pgr_step_rom.sv
module pgr_step_rom
  import pgr_pkg::*;
#(
  parameter int ENG_GFX_BIT    = 12,
  parameter int ENG_GATE_BIT   = 27,
  parameter int CLAMP_MASK_BIT = 0,
  parameter int CLAMP_VAL_BIT  = 1,
  parameter int OVR_EN_BIT     = 30,
  parameter int OVR_VAL_BIT    = 31
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  localparam logic [POS_W-1:0] P_GFX  = POS_W'(ENG_GFX_BIT);
  localparam logic [POS_W-1:0] P_GATE = POS_W'(ENG_GATE_BIT);
  localparam logic [POS_W-1:0] P_CMSK = POS_W'(CLAMP_MASK_BIT);
  localparam logic [POS_W-1:0] P_CVAL = POS_W'(CLAMP_VAL_BIT);
  localparam logic [POS_W-1:0] P_OEN  = POS_W'(OVR_EN_BIT);
  localparam logic [POS_W-1:0] P_OVAL = POS_W'(OVR_VAL_BIT);

  function automatic step_t mk(op_e op, reg_e rs, logic [POS_W-1:0] p, logic v);
    step_t s;
    s.op   = op;
    s.rsel = rs;
    s.pos  = p;
    s.val  = v;
    return s;
  endfunction

  always_comb begin
    case (idx)
      4'd0:    step = mk(OP_RMW,  RG_ENG,   P_GFX,  1'b0);
      4'd1:    step = mk(OP_READ, RG_ENG,   '0,     1'b0);
      4'd2:    step = mk(OP_RMW,  RG_ENG,   P_GATE, 1'b1);
      4'd3:    step = mk(OP_WAIT, RG_ENG,   '0,     1'b0);
      4'd4:    step = mk(OP_RMW,  RG_CLAMP, P_CVAL, 1'b1);
      4'd5:    step = mk(OP_RMW,  RG_CLAMP, P_CMSK, 1'b1);
      4'd6:    step = mk(OP_RMW,  RG_CLAMP, P_CMSK, 1'b0);
      4'd7:    step = mk(OP_RMW,  RG_THERM, P_OVAL, 1'b0);
      4'd8:    step = mk(OP_RMW,  RG_THERM, P_OEN,  1'b1);
      4'd9:    step = mk(OP_WAIT, RG_ENG,   '0,     1'b0);
      4'd10:   step = mk(OP_RMW,  RG_CLAMP, P_CVAL, 1'b0);
      4'd11:   step = mk(OP_RMW,  RG_CLAMP, P_CMSK, 1'b1);
      4'd12:   step = mk(OP_RMW,  RG_CLAMP, P_CMSK, 1'b0);
      4'd13:   step = mk(OP_RMW,  RG_ENG,   P_GATE, 1'b0);
      4'd14:   step = mk(OP_RMW,  RG_ENG,   P_GFX,  1'b1);
      default: step = mk(OP_READ, RG_ENG,   '0,     1'b0);
    endcase
  end

endmodule

// File: rtl/pgr_delay_timer.sv
module pgr_delay_timer #(
  parameter int COUNT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic running,
  output logic expire
);

  localparam int CW = $clog2(COUNT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(COUNT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = (cnt_q != '0);
  assign expire  = (cnt_q == CW'(1));

  // R7: a new wait is never loaded on top of a running one
  a_r7_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !running);

  // R7: expiry ends the count
  a_r7_expire_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !running);

endmodule

// File: rtl/pgr_bus_rmw.sv
module pgr_bus_rmw
  import pgr_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_rmw,
  input  logic [AW-1:0]    go_addr,
  input  logic [POS_W-1:0] go_pos,
  input  logic             go_val,
  output logic             ack,
  output logic             eng_busy,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready
);

  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} e_e;

  e_e               st_q;
  logic             rmw_q;
  logic             val_q;
  logic [POS_W-1:0] pos_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             rd_hs;
  logic             wr_hs;
  logic [DW-1:0]    merged;

  assign rd_hs  = (st_q == E_RD) && bus_ready;
  assign wr_hs  = (st_q == E_WR) && bus_ready;
  assign merged = DW'(put_bit(64'(bus_rdata), pos_q, val_q));
  assign ack    = (rd_hs && !rmw_q) || wr_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      rmw_q   <= 1'b0;
      val_q   <= 1'b0;
      pos_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        E_IDLE: if (go) begin
          st_q   <= E_RD;
          rmw_q  <= go_rmw;
          val_q  <= go_val;
          pos_q  <= go_pos;
          addr_q <= go_addr;
        end
        E_RD: if (bus_ready) begin
          if (rmw_q) begin
            st_q    <= E_WR;
            wdata_q <= merged;
          end else begin
            st_q <= E_IDLE;
          end
        end
        E_WR: if (bus_ready) begin
          st_q    <= E_IDLE;
          wdata_q <= '0;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign eng_busy  = (st_q != E_IDLE);
  assign bus_req   = (st_q != E_IDLE);
  assign bus_we    = (st_q == E_WR);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  // R4: request and its payload hold while the target stalls
  a_r4_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata)));

  // R5: a field-change read is followed at once by a write to the same address
  //     that differs from the read word in at most one bit
  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && rmw_q) |=> (bus_req && bus_we && bus_addr == $past(bus_addr)
                          && $countones(bus_wdata ^ $past(bus_rdata)) <= 1));

  // R4: a new command is only taken when the engine is free
  a_r4_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !eng_busy);

endmodule

// File: rtl/pgr_release_seq.sv
module pgr_release_seq
  import pgr_pkg::*;
#(
  parameter int            AW             = 24,
  parameter int            DW             = 32,
  parameter int            CYCLES_PER_MS  = 100000,
  parameter int            DELAY_MS       = 50,
  parameter logic [AW-1:0] ENG_ADDR       = AW'(32'h0000_0200),
  parameter logic [AW-1:0] CLAMP_ADDR     = AW'(32'h0010_A78C),
  parameter logic [AW-1:0] THERM_ADDR     = AW'(32'h0002_0004),
  parameter int            ENG_GFX_BIT    = 12,
  parameter int            ENG_GATE_BIT   = 27,
  parameter int            CLAMP_MASK_BIT = 0,
  parameter int            CLAMP_VAL_BIT  = 1,
  parameter int            OVR_EN_BIT     = 30,
  parameter int            OVR_VAL_BIT    = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);

  localparam int WAIT_CYC = wait_cycles(CYCLES_PER_MS, DELAY_MS);

  typedef enum logic [1:0] {Q_IDLE, Q_LAUNCH, Q_BUS, Q_DLY} q_e;

  q_e               st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  step_t            step;
  logic             eng_go;
  logic             tmr_load;
  logic             eng_ack;
  logic             eng_busy;
  logic             tmr_running;
  logic             tmr_expire;
  logic             step_done;
  logic             start_taken;
  logic [AW-1:0]    step_addr;

  function automatic logic [AW-1:0] addr_of(reg_e rs);
    case (rs)
      RG_CLAMP: return CLAMP_ADDR;
      RG_THERM: return THERM_ADDR;
      default:  return ENG_ADDR;
    endcase
  endfunction

  pgr_step_rom #(
    .ENG_GFX_BIT    (ENG_GFX_BIT),
    .ENG_GATE_BIT   (ENG_GATE_BIT),
    .CLAMP_MASK_BIT (CLAMP_MASK_BIT),
    .CLAMP_VAL_BIT  (CLAMP_VAL_BIT),
    .OVR_EN_BIT     (OVR_EN_BIT),
    .OVR_VAL_BIT    (OVR_VAL_BIT)
  ) u_rom (
    .idx  (idx_q),
    .step (step)
  );

  assign step_addr   = addr_of(step.rsel);
  assign eng_go      = (st_q == Q_LAUNCH) && (step.op != OP_WAIT);
  assign tmr_load    = (st_q == Q_LAUNCH) && (step.op == OP_WAIT);
  assign step_done   = ((st_q == Q_BUS) && eng_ack) || ((st_q == Q_DLY) && tmr_expire);
  assign start_taken = (st_q == Q_IDLE) && start;

  pgr_bus_rmw #(.AW(AW), .DW(DW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (eng_go),
    .go_rmw    (step.op == OP_RMW),
    .go_addr   (step_addr),
    .go_pos    (step.pos),
    .go_val    (step.val),
    .ack       (eng_ack),
    .eng_busy  (eng_busy),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
  );

  pgr_delay_timer #(.COUNT(WAIT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .running (tmr_running),
    .expire  (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= Q_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        Q_IDLE: if (start_taken) begin
          idx_q <= '0;
          st_q  <= Q_LAUNCH;
        end
        Q_LAUNCH: st_q <= (step.op == OP_WAIT) ? Q_DLY : Q_BUS;
        Q_BUS, Q_DLY: if (step_done) begin
          if (is_last(idx_q)) begin
            st_q   <= Q_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= Q_LAUNCH;
          end
        end
        default: st_q <= Q_IDLE;
      endcase
    end
  end

  assign busy = (st_q != Q_IDLE);
  assign done = done_q;

  // R2: done is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: done follows a busy cycle and busy is already low with it
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3: a start during a run does not rewind the step index
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && idx_q != '0) |=> (idx_q != '0));

  // R10: wait timer and bus engine are never active together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_running && eng_busy));

  // R1: no bus activity while idle
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

endmodule

// File: tb/test_pgr_release_seq.sv
module test_pgr_release_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CPM     = 2;
  localparam int TB_MS      = 50;
  localparam int WAITN      = TB_CPM * TB_MS;
  localparam int A_ENG      = 32'h200;
  localparam int A_CLAMP    = 32'h10A78C;
  localparam int A_THERM    = 32'h20004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, bus_req, bus_we, bus_ready;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  pgr_release_seq #(.CYCLES_PER_MS(TB_CPM), .DELAY_MS(TB_MS)) i_pgr_release_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // register model and transfer trace
  logic [31:0] m_eng, m_clamp, m_therm;
  int          lat = 0;
  int          wcnt = 0;
  int          gap = 0;
  int          txn_n = 0;
  int          hold_err = 0;
  logic [23:0] t_addr [0:63];
  logic        t_we   [0:63];
  logic [31:0] t_data [0:63];
  int          t_gap  [0:63];
  logic        prev_stall = 1'b0;
  logic [23:0] prev_addr;
  logic [31:0] prev_wdata;

  assign bus_ready = bus_req && (wcnt >= lat);

  always_comb begin
    case (32'(bus_addr))
      A_ENG:   bus_rdata = m_eng;
      A_CLAMP: bus_rdata = m_clamp;
      A_THERM: bus_rdata = m_therm;
      default: bus_rdata = 32'hDEAD_BEEF;
    endcase
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (bus_req && !bus_ready) begin
        if (prev_stall && (bus_addr != prev_addr || bus_wdata != prev_wdata)) hold_err <= hold_err + 1;
        prev_stall <= 1'b1;
        prev_addr  <= bus_addr;
        prev_wdata <= bus_wdata;
        wcnt       <= wcnt + 1;
      end else begin
        prev_stall <= 1'b0;
        wcnt       <= 0;
      end
      if (bus_req && bus_ready) begin
        if (txn_n < 64) begin
          t_addr[txn_n] <= bus_addr;
          t_we[txn_n]   <= bus_we;
          t_data[txn_n] <= bus_we ? bus_wdata : bus_rdata;
          t_gap[txn_n]  <= gap;
        end
        txn_n <= txn_n + 1;
        gap   <= 0;
        if (bus_we) begin
          case (32'(bus_addr))
            A_ENG:   m_eng   <= bus_wdata;
            A_CLAMP: m_clamp <= bus_wdata;
            A_THERM: m_therm <= bus_wdata;
            default: ;
          endcase
        end
      end else if (!bus_req) begin
        gap <= gap + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 field change eng, 1 field change clamp, 2 field change therm, 3 read eng, 4 wait
  task automatic spec_step(input int i, output int kind, output int pos, output logic v);
    kind = 0; pos = 0; v = 1'b0;
    case (i)
      0:  begin kind = 0; pos = 12; v = 1'b0; end
      1:  kind = 3;
      2:  begin kind = 0; pos = 27; v = 1'b1; end
      3:  kind = 4;
      4:  begin kind = 1; pos = 1;  v = 1'b1; end
      5:  begin kind = 1; pos = 0;  v = 1'b1; end
      6:  begin kind = 1; pos = 0;  v = 1'b0; end
      7:  begin kind = 2; pos = 31; v = 1'b0; end
      8:  begin kind = 2; pos = 30; v = 1'b1; end
      9:  kind = 4;
      10: begin kind = 1; pos = 1;  v = 1'b0; end
      11: begin kind = 1; pos = 0;  v = 1'b1; end
      12: begin kind = 1; pos = 0;  v = 1'b0; end
      13: begin kind = 0; pos = 27; v = 1'b0; end
      14: begin kind = 0; pos = 12; v = 1'b1; end
      default: kind = 3;
    endcase
  endtask

  task automatic run_case(input string name, input logic [31:0] e0, input logic [31:0] c0,
                          input logic [31:0] t0, input int lat_in, input int poke_a, input int poke_b);
    logic [31:0] cur [0:2];
    int dcount = 0;
    int after = -1;
    int k = 0;
    logic after_wait = 1'b0;
    logic first = 1'b1;
    $display("-- %s", name);
    @(negedge clk);
    m_eng = e0; m_clamp = c0; m_therm = t0;
    cur[0] = e0; cur[1] = c0; cur[2] = t0;
    lat = lat_in; txn_n = 0; hold_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", longint'(busy), 1);
    for (int cyc = 1; cyc < 3000; cyc++) begin
      @(negedge clk);
      start = (cyc == poke_a || cyc == poke_b) && busy;
      if (done) begin
        dcount++;
        check("R2", "busy low with done", longint'(busy), 0);
        if (after < 0) after = 0;
      end
      if (after >= 0) begin
        after++;
        if (after > 6) break;
      end
    end
    start = 1'b0;
    check("R2", "done pulses per run", dcount, 1);
    check("R3", "transfer count (extra start ignored)", txn_n, 26);
    check("R4", "payload changed during stall", hold_err, 0);
    for (int i = 0; i < 16; i++) begin
      int kind, pos, a, ri;
      logic v;
      logic [31:0] nw;
      spec_step(i, kind, pos, v);
      if (kind == 4) begin after_wait = 1'b1; continue; end
      ri = (kind == 3) ? 0 : kind;
      a  = (ri == 0) ? A_ENG : (ri == 1) ? A_CLAMP : A_THERM;
      if (k >= txn_n) begin
        check("R6", $sformatf("missing transfer %0d", k), txn_n, k + 1);
        break;
      end
      check("R9", $sformatf("read addr txn %0d", k), longint'(t_addr[k]), a);
      check("R6", $sformatf("read dir txn %0d", k), longint'(t_we[k]), 0);
      check("R5", $sformatf("read data txn %0d", k), longint'(t_data[k]), longint'(cur[ri]));
      if (!first)
        check(after_wait ? "R7" : "R8", $sformatf("gap before txn %0d", k), t_gap[k],
              after_wait ? WAITN + 2 : 1);
      first = 1'b0; after_wait = 1'b0; k++;
      if (kind != 3) begin
        nw = cur[ri];
        nw[pos] = v;
        check("R5", $sformatf("write dir txn %0d", k), longint'(t_we[k]), 1);
        check("R5", $sformatf("write addr txn %0d", k), longint'(t_addr[k]), a);
        check("R6", $sformatf("write data txn %0d", k), longint'(t_data[k]), longint'(nw));
        check("R8", $sformatf("rmw gap txn %0d", k), t_gap[k], 0);
        cur[ri] = nw; k++;
      end
    end
    check("R5", "final engine reg", longint'(m_eng), longint'(cur[0]));
    check("R5", "final clamp reg", longint'(m_clamp), longint'(cur[1]));
    check("R5", "final thermal reg", longint'(m_therm), longint'(cur[2]));
    check("R10", "bus quiet after done", longint'(bus_req), 0);
  endtask

  task automatic test_reset;
    check("R1", "busy at reset", longint'(busy), 0);
    check("R1", "done at reset", longint'(done), 0);
    check("R1", "bus_req at reset", longint'(bus_req), 0);
    repeat (5) @(negedge clk);
    check("R1", "no transfers without start", txn_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_case("zero latency, mixed bits", 32'h1234_5678, 32'h0000_0000, 32'h8000_1111, 0, -1, -1);
    run_case("latency 2, start poked mid-access and mid-wait", 32'h0800_1000, 32'hFFFF_FFFC,
             32'h4000_0000, 2, 5, 60);
    run_case("latency 3, all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 2, 200);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule